// File: doc/BRIEF.md
# High-Half Register Arithmetic Unit

This execution unit holds a file of general registers, each 64 bits wide, and runs a family of operations that treat only the upper 32-bit half of a register as their destination. The first operand is always the upper half of a source register. The second operand is the upper half or the lower half of another register, a 32-bit immediate, or a 32-bit storage operand supplied by the memory pipeline. When a result is written, only the upper half of the destination register changes. Code that needs only 32-bit values can therefore use the upper halves as a second bank of registers.

The supported operations are signed and logical add and subtract, signed and logical compare, a decrement-and-branch on the upper half, and byte and halfword loads into the upper half with sign or zero extension. Each operation that sets the 2-bit condition code does so by a fixed rule. One logical immediate add variant leaves the condition code as it was. Other units write whole registers through a separate write port, and a read port returns any register.

An operation is presented with `op_valid` for one cycle. Register writes, the condition code and the branch-taken flag all update on that clock edge.

Top module: `hiword_alu`

## Requirements
- R1: After reset every register reads zero, `cc` is 0 and `br_taken` is 0.
- R2: Signed add writes `rd.hi = ra.hi + X`. X is `rb.hi` for code 0, `rb.lo` for code 1 and `imm` for code 2. `cc` becomes 3 on two's-complement overflow, otherwise 0 for a zero result, 1 for a negative result and 2 for a positive result. The result wraps on overflow.
- R3: Logical add uses the same operand forms as R2 under codes 3, 4 and 5. `cc` becomes {carry-out, result nonzero}: 0 means zero with no carry, 1 nonzero with no carry, 2 zero with carry, 3 nonzero with carry.
- R4: Code 6 writes `rd.hi = ra.hi + imm` and leaves `cc` unchanged.
- R5: Subtract computes `ra.hi - rb.hi` under codes 7 and 9, and `ra.hi - rb.lo` under codes 8 and 10. Codes 7 and 8 set `cc` as in R2. Codes 9 and 10 compute `ra.hi + ~X + 1` and set `cc` as in R3 from that carry.
- R6: Compare takes `ra.hi` against `rb.hi`, `rb.lo`, `mem_opnd` or `imm`. Codes 11 to 14 compare signed and codes 15 to 18 compare unsigned, with the operands in that order. `cc` becomes 0 for equal, 1 if `ra.hi` is lower and 2 if it is higher. No register is written.
- R7: Code 19 writes `rd.hi = rd.hi - 1` modulo 2^32. `br_taken` is 1 in the following cycle exactly when the new value is nonzero. `cc` is unchanged. `br_taken` is 0 after any cycle without a code 19 operation.
- R8: Codes 20 to 23 load `mem_opnd[7:0]` sign-extended, `mem_opnd[7:0]` zero-extended, `mem_opnd[15:0]` sign-extended and `mem_opnd[15:0]` zero-extended, in that order, into `rd.hi`. `cc` is unchanged.
- R9: The upper half is register bits [63:32]; these are bits 0 to 31 when bits are numbered from the most significant end. Every write by the unit leaves bits [31:0] of the destination unchanged.
- R10: Codes 24 to 31, and any cycle with `op_valid` low, change no register and no `cc`.
- R11: When the write port and an operation target the same register in one cycle, the lower half takes `ext_data[31:0]` and the upper half takes the operation's result.
- R12: Operands are read from the register state before the edge. All effects are visible after the edge on which `op_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| rd_sel | input | 4 | Destination register |
| ra_sel | input | 4 | First source register (upper half) |
| rb_sel | input | 4 | Second source register |
| imm | input | 32 | Immediate operand |
| mem_opnd | input | 32 | Storage operand from memory pipeline |
| ext_we | input | 1 | Whole-register write enable |
| ext_sel | input | 4 | Whole-register write index |
| ext_data | input | 64 | Whole-register write data |
| peek_sel | input | 4 | Read port index |
| peek_data | output | 64 | Read port data |
| cc | output | 2 | Condition code |
| br_taken | output | 1 | Decrement-and-branch taken |

## Verification
The arithmetic is tried with operand pairs that give a positive, a negative, a zero and an overflowing result. These tell the four signed condition codes apart. The logical forms are tried with values near 2^32, which separate carry from the zero/nonzero flag. Compares use pairs such as -1 against 1, where the signed and unsigned orderings disagree. Every operand source (high, low, immediate, storage) is exercised, and every destination has a known lower-half pattern that must survive. Decrement-and-branch is stepped through 2, 1 and 0 to cover taken, not-taken and wraparound.

// File: rtl/hiword_alu.sv
module hiword_alu #(
  parameter int NREG = 16,
  parameter int XLEN = 64,
  localparam int RW = $clog2(NREG),
  localparam int HW = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [4:0]      op_code,
  input  logic [RW-1:0]   rd_sel,
  input  logic [RW-1:0]   ra_sel,
  input  logic [RW-1:0]   rb_sel,
  input  logic [HW-1:0]   imm,
  input  logic [HW-1:0]   mem_opnd,
  input  logic            ext_we,
  input  logic [RW-1:0]   ext_sel,
  input  logic [XLEN-1:0] ext_data,
  input  logic [RW-1:0]   peek_sel,
  output logic [XLEN-1:0] peek_data,
  output logic [1:0]      cc,
  output logic            br_taken
);
  typedef enum logic [2:0] {K_NONE, K_SARITH, K_LARITH, K_LNOCC, K_SCMP, K_LCMP, K_BCT, K_LOAD} kind_t;

  logic [XLEN-1:0] rf [NREG];
  logic [HW-1:0] a_hi, b_hi, b_lo, d_hi, opb, ld_val;
  logic [HW:0]   sum;
  logic [HW-1:0] res, dec, wval;
  logic          do_sub, ovf, hi_we, cc_we;
  logic [1:0]    cc_nx;
  kind_t         kind;

  assign a_hi = rf[ra_sel][XLEN-1:HW];
  assign b_hi = rf[rb_sel][XLEN-1:HW];
  assign b_lo = rf[rb_sel][HW-1:0];
  assign d_hi = rf[rd_sel][XLEN-1:HW];
  assign peek_data = rf[peek_sel];

  always_comb begin
    kind = K_NONE; opb = b_hi; do_sub = 1'b0; ld_val = '0;
    case (op_code)
      5'd0:  kind = K_SARITH;
      5'd1:  begin kind = K_SARITH; opb = b_lo; end
      5'd2:  begin kind = K_SARITH; opb = imm; end
      5'd3:  kind = K_LARITH;
      5'd4:  begin kind = K_LARITH; opb = b_lo; end
      5'd5:  begin kind = K_LARITH; opb = imm; end
      5'd6:  begin kind = K_LNOCC; opb = imm; end
      5'd7:  begin kind = K_SARITH; do_sub = 1'b1; end
      5'd8:  begin kind = K_SARITH; do_sub = 1'b1; opb = b_lo; end
      5'd9:  begin kind = K_LARITH; do_sub = 1'b1; end
      5'd10: begin kind = K_LARITH; do_sub = 1'b1; opb = b_lo; end
      5'd11: kind = K_SCMP;
      5'd12: begin kind = K_SCMP; opb = b_lo; end
      5'd13: begin kind = K_SCMP; opb = mem_opnd; end
      5'd14: begin kind = K_SCMP; opb = imm; end
      5'd15: kind = K_LCMP;
      5'd16: begin kind = K_LCMP; opb = b_lo; end
      5'd17: begin kind = K_LCMP; opb = mem_opnd; end
      5'd18: begin kind = K_LCMP; opb = imm; end
      5'd19: kind = K_BCT;
      5'd20: begin kind = K_LOAD; ld_val = {{(HW-8){mem_opnd[7]}}, mem_opnd[7:0]}; end
      5'd21: begin kind = K_LOAD; ld_val = {{(HW-8){1'b0}}, mem_opnd[7:0]}; end
      5'd22: begin kind = K_LOAD; ld_val = {{(HW-16){mem_opnd[15]}}, mem_opnd[15:0]}; end
      5'd23: begin kind = K_LOAD; ld_val = {{(HW-16){1'b0}}, mem_opnd[15:0]}; end
      default: kind = K_NONE;
    endcase
  end

  assign sum = {1'b0, a_hi} + {1'b0, do_sub ? ~opb : opb} + {{HW{1'b0}}, do_sub};
  assign res = sum[HW-1:0];
  assign ovf = (do_sub ? (a_hi[HW-1] != opb[HW-1]) : (a_hi[HW-1] == opb[HW-1]))
               && (res[HW-1] != a_hi[HW-1]);
  assign dec = d_hi - 1'b1;

  always_comb begin
    hi_we = 1'b0; cc_we = 1'b0; cc_nx = cc; wval = res;
    case (kind)
      K_SARITH: begin
        hi_we = 1'b1; cc_we = 1'b1;
        cc_nx = ovf ? 2'd3 : (res == '0) ? 2'd0 : res[HW-1] ? 2'd1 : 2'd2;
      end
      K_LARITH: begin hi_we = 1'b1; cc_we = 1'b1; cc_nx = {sum[HW], |res}; end
      K_LNOCC:  hi_we = 1'b1;
      K_SCMP: begin
        cc_we = 1'b1;
        cc_nx = (a_hi == opb) ? 2'd0 : ($signed(a_hi) < $signed(opb)) ? 2'd1 : 2'd2;
      end
      K_LCMP: begin
        cc_we = 1'b1;
        cc_nx = (a_hi == opb) ? 2'd0 : (a_hi < opb) ? 2'd1 : 2'd2;
      end
      K_BCT:  begin hi_we = 1'b1; wval = dec; end
      K_LOAD: begin hi_we = 1'b1; wval = ld_val; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      cc <= 2'd0;
      br_taken <= 1'b0;
    end else begin
      if (ext_we) rf[ext_sel] <= ext_data;
      if (op_valid && hi_we) rf[rd_sel][XLEN-1:HW] <= wval;
      if (op_valid && cc_we) cc <= cc_nx;
      br_taken <= op_valid && (kind == K_BCT) && (dec != '0);
    end
  end
endmodule

module hiword_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_code,
  input logic [1:0] cc,
  input logic       br_taken
);
  // R6
  cmp_cc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd11 && op_code <= 5'd18) |=> (cc != 2'd3));
  // R4
  nocc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'd6) |=> $stable(cc));
  // R8
  load_cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd20 && op_code <= 5'd23) |=> $stable(cc));
  // R7
  taken_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == 5'd19) |=> !br_taken);
  // R10
  idle_cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code >= 5'd24) |=> $stable(cc));
endmodule

bind hiword_alu hiword_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .cc(cc), .br_taken(br_taken));

// File: tb/hiword_alu_bench.sv
`timescale 1ns/1ps
module hiword_alu_bench;
  logic clk = 0, rst_n = 0, op_valid = 0, ext_we = 0;
  logic [4:0] op_code = 0;
  logic [3:0] rd_sel = 0, ra_sel = 0, rb_sel = 0, ext_sel = 0, peek_sel = 0;
  logic [31:0] imm = 0, mem_opnd = 0;
  logic [63:0] ext_data = 0, peek_data;
  logic [1:0] cc;
  logic br_taken;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  hiword_alu u_hiword_alu (.*);

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setreg(input logic [3:0] i, input logic [63:0] v);
    @(negedge clk); ext_we = 1; ext_sel = i; ext_data = v;
    @(negedge clk); ext_we = 0;
  endtask

  task automatic getreg(input logic [3:0] i, output logic [63:0] v);
    peek_sel = i; #0.1; v = peek_data;
  endtask

  task automatic exec(input logic [4:0] c, input logic [3:0] d, a, b,
                      input logic [31:0] im, input logic [31:0] mo);
    @(negedge clk); op_valid = 1; op_code = c; rd_sel = d; ra_sel = a; rb_sel = b;
    imm = im; mem_opnd = mo;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    getreg(4'd5, v); chk("R1 reg", v, 0);
    chk("R1 cc", cc, 0); chk("R1 taken", br_taken, 0);
  endtask

  task automatic t_sadd;
    logic [63:0] v;
    setreg(1, 64'h00000005_0000AAAA); setreg(2, 64'h00000007_FFFFFFF0);
    setreg(3, 64'h0_12345678);
    exec(0, 3, 1, 2, 0, 0); getreg(3, v);
    chk("R2 add hh", v, 64'h0000000C_12345678); chk("R9 low kept", v[31:0], 32'h12345678);
    chk("R2 cc pos", cc, 2);
    exec(1, 3, 1, 2, 0, 0); getreg(3, v);
    chk("R2 add hl", v[63:32], 32'hFFFFFFF5); chk("R2 cc neg", cc, 1);
    setreg(4, 64'h7FFFFFFF_00000000);
    exec(2, 3, 4, 0, 1, 0); getreg(3, v);
    chk("R2 add imm ovf", v[63:32], 32'h80000000); chk("R2 cc ovf", cc, 3);
    exec(2, 3, 1, 0, 32'hFFFFFFFB, 0); getreg(3, v);
    chk("R2 add zero", v[63:32], 0); chk("R2 cc zero", cc, 0);
  endtask

  task automatic t_ladd;
    logic [63:0] v;
    setreg(5, 64'hFFFFFFFF_00000002);
    exec(5, 6, 5, 0, 1, 0); getreg(6, v);
    chk("R3 zero carry", v[63:32], 0); chk("R3 cc2", cc, 2);
    exec(4, 6, 5, 5, 0, 0); getreg(6, v);
    chk("R3 hl", v[63:32], 1); chk("R3 cc3", cc, 3);
    exec(3, 6, 1, 2, 0, 0); getreg(6, v);
    chk("R3 hh", v[63:32], 12); chk("R3 cc1", cc, 1);
    setreg(7, 64'h0000000A_00000000);
    exec(5, 6, 7, 0, 32'hFFFFFFFF, 0); getreg(6, v);
    chk("R3 signed imm", v[63:32], 9); chk("R3 cc3 imm", cc, 3);
  endtask

  task automatic t_nocc;
    logic [63:0] v;
    exec(6, 8, 7, 0, 32'hFFFFFFF6, 0); getreg(8, v);
    chk("R4 result", v[63:32], 0); chk("R4 cc kept", cc, 3);
  endtask

  task automatic t_sub;
    logic [63:0] v;
    setreg(9, 64'h00000003_00000005);
    exec(8, 10, 9, 9, 0, 0); getreg(10, v);
    chk("R5 sub hl", v[63:32], 32'hFFFFFFFE); chk("R5 cc neg", cc, 1);
    setreg(11, 64'h80000000_00000001);
    exec(8, 10, 11, 11, 0, 0); getreg(10, v);
    chk("R5 sub ovf", v[63:32], 32'h7FFFFFFF); chk("R5 cc ovf", cc, 3);
    exec(9, 10, 1, 1, 0, 0); getreg(10, v);
    chk("R5 lsub zero", v[63:32], 0); chk("R5 lcc2", cc, 2);
    exec(10, 10, 9, 9, 0, 0); getreg(10, v);
    chk("R5 lsub borrow", v[63:32], 32'hFFFFFFFE); chk("R5 lcc1", cc, 1);
    exec(7, 10, 2, 1, 0, 0); getreg(10, v);
    chk("R5 sub hh", v[63:32], 2); chk("R5 cc pos", cc, 2);
  endtask

  task automatic t_cmp;
    logic [63:0] v0, v1;
    setreg(12, 64'hFFFFFFFF_00000001);
    getreg(13, v0);
    exec(12, 13, 12, 12, 0, 0); chk("R6 signed lo", cc, 1);
    exec(16, 13, 12, 12, 0, 0); chk("R6 logical hi", cc, 2);
    exec(13, 13, 12, 0, 0, 32'hFFFFFFFF); chk("R6 mem eq", cc, 0);
    exec(14, 13, 1, 0, 32'hFFFFFFFF, 0); chk("R6 imm signed hi", cc, 2);
    exec(18, 13, 1, 0, 32'hFFFFFFFF, 0); chk("R6 imm logical lo", cc, 1);
    exec(11, 13, 1, 2, 0, 0); chk("R6 hh lo", cc, 1);
    exec(17, 13, 1, 0, 0, 5); chk("R6 mem logical eq", cc, 0);
    getreg(13, v1); chk("R6 no write", v1, v0);
  endtask

  task automatic t_bct;
    logic [63:0] v;
    setreg(14, 64'h00000002_CAFEF00D);
    exec(19, 14, 0, 0, 0, 0); getreg(14, v);
    chk("R7 dec", v, 64'h00000001_CAFEF00D); chk("R7 taken", br_taken, 1);
    chk("R7 cc kept", cc, 0);
    exec(19, 14, 0, 0, 0, 0); getreg(14, v);
    chk("R7 dec zero", v[63:32], 0); chk("R7 not taken", br_taken, 0);
    exec(19, 14, 0, 0, 0, 0); getreg(14, v);
    chk("R7 wrap", v[63:32], 32'hFFFFFFFF); chk("R7 wrap taken", br_taken, 1);
    @(negedge clk); chk("R7 pulse ends", br_taken, 0);
  endtask

  task automatic t_load;
    logic [63:0] v;
    setreg(15, 64'h11111111_89ABCDEF);
    exec(20, 15, 0, 0, 0, 32'h12348180); getreg(15, v);
    chk("R8 lb signed", v, 64'hFFFFFF80_89ABCDEF);
    exec(21, 15, 0, 0, 0, 32'h12348180); getreg(15, v);
    chk("R8 lb zero", v[63:32], 32'h00000080);
    exec(22, 15, 0, 0, 0, 32'h12348180); getreg(15, v);
    chk("R8 lh signed", v[63:32], 32'hFFFF8180);
    exec(23, 15, 0, 0, 0, 32'h12348180); getreg(15, v);
    chk("R8 lh zero", v, 64'h00008180_89ABCDEF); chk("R8 cc kept", cc, 0);
  endtask

  task automatic t_undef;
    logic [63:0] v;
    exec(14, 0, 1, 0, 32'hFFFFFFFF, 0);
    exec(27, 15, 1, 2, 32'h55, 32'h55); getreg(15, v);
    chk("R10 undef reg", v, 64'h00008180_89ABCDEF); chk("R10 undef cc", cc, 2);
    @(negedge clk); rd_sel = 15; op_code = 21; mem_opnd = 32'h7;
    @(negedge clk); getreg(15, v);
    chk("R10 idle reg", v, 64'h00008180_89ABCDEF);
  endtask

  task automatic t_collide;
    logic [63:0] v;
    @(negedge clk); ext_we = 1; ext_sel = 3; ext_data = 64'hAAAAAAAA_BBBBBBBB;
    op_valid = 1; op_code = 0; rd_sel = 3; ra_sel = 1; rb_sel = 2;
    @(negedge clk); ext_we = 0; op_valid = 0; getreg(3, v);
    chk("R11 R12 collide", v, 64'h0000000C_BBBBBBBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_sadd; t_ladd; t_nocc; t_sub; t_cmp; t_bct; t_load; t_undef; t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule